// File: doc/BRIEF.md
# Address Window Decoder

This block tells a memory-moving engine which target an address belongs to. Software programs a set of address windows. Each window has a base word, a size-mask word and a two-bit access field in one shared control word. The engine then presents a 32-bit address together with a read/write flag. One clock later the block answers with four results:

- whether the access lands in a permitted window;
- which window was chosen;
- the 8-bit target attribute stored with that window;
- a miss flag when no permitted window claims the address.

Windows are compared only on the upper 16 address bits. A set bit in a window's mask marks an address bit that does not take part in the comparison. This gives windows of power-of-two size that sit on matching alignment; for example, a mask word of 0x03FF0000 gives a 64 MB window and 0x0FFF0000 gives 256 MB. Every configuration word can be read back in full, so software can save a whole window setup and restore it later. An extra address-override word is kept for software. It resets to zero and has no effect on decoding.

Top module: `addr_window_decoder`

## Requirements
- R1: After reset, every configuration word reads zero (override word included) and `rsp_valid` is low.
- R2: Configuration slots are numbered as follows: slot 0 is the shared control word and slot 1 is the override word. For window i, slot 2+2i is its base word and slot 3+2i is its mask word. A write to a slot stores all 32 bits, and `cfg_rd_data` returns them combinationally from `cfg_rd_idx`.
- R3: `rsp_valid` is `req_valid` delayed by exactly one clock. While `req_valid` is low, the response fields keep their previous values.
- R4: Window i matches when its access field is not 00 and `(req_addr[31:16] ^ base[31:16]) & ~mask[31:16]` is zero. Bits [15:0] of the address, base and mask take no part in the match.
- R5: When several windows match, the one with the lowest index is chosen.
- R6: When no window matches, the response gives `rsp_miss`=1, `rsp_hit`=0, `rsp_win`=0 and `rsp_attr`=0.
- R7: Window i's access field is at control bits [17+2i:16+2i]. Bit 16+2i permits reads and bit 17+2i permits writes. If the chosen window lacks permission for the request type, the response gives `rsp_miss`=1, `rsp_hit`=0, `rsp_attr`=0 and `rsp_win`=i. No higher-index window is tried instead.
- R8: On a permitted hit, `rsp_attr` equals bits [15:8] of the chosen window's base word.
- R9: Writes to slot indices at or above 2+2·NUM_WIN change nothing, and reads of those indices return zero.
- R10: In every valid response, exactly one of `rsp_hit` and `rsp_miss` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_idx | input | RIDX_W (4) | Slot written |
| cfg_wr_data | input | 32 | Write data |
| cfg_rd_idx | input | RIDX_W (4) | Slot read |
| cfg_rd_data | output | 32 | Read data, combinational |
| req_valid | input | 1 | Decode request strobe |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_addr | input | 32 | Address to decode |
| rsp_valid | output | 1 | Response strobe |
| rsp_hit | output | 1 | Permitted window found |
| rsp_miss | output | 1 | No match or access denied |
| rsp_win | output | WIDX_W (2) | Chosen window index |
| rsp_attr | output | 8 | Target attribute of the hit window |

## Verification
Each decode result appears at the first clock edge after the request is sampled. The bench drives inputs on falling edges and reads the response at the next falling edge, half a cycle after that edge. One further falling edge later, it checks that `rsp_valid` has dropped and that the response fields have not moved. Configuration writes take effect at one clock edge. Read data follows `cfg_rd_idx` with no clock, so readback is checked a short delay after the index is driven, and a request is issued only after the preceding write edge. Each configuration is swept across a regular grid of upper-address values in both access directions, with the expected answer computed from a shadow copy of the programmed words.

// File: rtl/awd_pkg.sv
package awd_pkg;

   localparam int unsigned AWD_WORD_W  = 32;
   localparam int unsigned AWD_HI_W    = 16;
   localparam int unsigned AWD_ATTR_W  = 8;
   localparam int unsigned AWD_ATTR_LSB = 8;
   localparam int unsigned AWD_FLD_LSB = 16;
   localparam int unsigned AWD_MAX_WIN = 8;

   localparam int unsigned AWD_SLOT_CTRL = 0;
   localparam int unsigned AWD_SLOT_OVRD = 1;
   localparam int unsigned AWD_SLOT_WIN0 = 2;

   typedef logic [AWD_WORD_W-1:0] awd_word_t;
   typedef logic [AWD_HI_W-1:0]   awd_hi_t;
   typedef logic [AWD_ATTR_W-1:0] awd_attr_t;

   function automatic int unsigned awd_base_slot(input int unsigned win);
      return AWD_SLOT_WIN0 + 2 * win;
   endfunction

   function automatic int unsigned awd_mask_slot(input int unsigned win);
      return AWD_SLOT_WIN0 + 2 * win + 1;
   endfunction

   function automatic int unsigned awd_fld_lsb(input int unsigned win);
      return AWD_FLD_LSB + 2 * win;
   endfunction

endpackage

// File: rtl/awd_regs.sv
module awd_regs
   import awd_pkg::*;
#(
   parameter int unsigned NUM_WIN = 4,
   parameter int unsigned RIDX_W  = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [RIDX_W-1:0]             wr_idx,
   input  awd_word_t                     wr_data,
   input  logic [RIDX_W-1:0]             rd_idx,
   output awd_word_t                     rd_data,
   output awd_word_t                     ctrl_q,
   output logic [NUM_WIN-1:0][AWD_WORD_W-1:0] base_q,
   output logic [NUM_WIN-1:0][AWD_WORD_W-1:0] mask_q
);

   localparam int unsigned NUM_SLOTS = AWD_SLOT_WIN0 + 2 * NUM_WIN;

   awd_word_t ovrd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (wr_en && wr_idx == RIDX_W'(AWD_SLOT_CTRL)) begin
         ctrl_q <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovrd_q <= '0;
      end else if (wr_en && wr_idx == RIDX_W'(AWD_SLOT_OVRD)) begin
         ovrd_q <= wr_data;
      end
   end

   for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            base_q[g] <= '0;
         end else if (wr_en && wr_idx == RIDX_W'(awd_base_slot(g))) begin
            base_q[g] <= wr_data;
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mask_q[g] <= '0;
         end else if (wr_en && wr_idx == RIDX_W'(awd_mask_slot(g))) begin
            mask_q[g] <= wr_data;
         end
      end
   end

   always_comb begin
      rd_data = '0;
      if (rd_idx == RIDX_W'(AWD_SLOT_CTRL)) rd_data = ctrl_q;
      if (rd_idx == RIDX_W'(AWD_SLOT_OVRD)) rd_data = ovrd_q;
      for (int i = 0; i < NUM_WIN; i++) begin
         if (rd_idx == RIDX_W'(awd_base_slot(i))) rd_data = base_q[i];
         if (rd_idx == RIDX_W'(awd_mask_slot(i))) rd_data = mask_q[i];
      end
   end

   // R2: a control write lands in full on the next edge
   a_r2_ctrl_store: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx == RIDX_W'(AWD_SLOT_CTRL)) |=> (ctrl_q == $past(wr_data)));

   // R9: out-of-range slots touch no shared word
   a_r9_oob_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && 32'(wr_idx) >= NUM_SLOTS) |=> ($stable(ctrl_q) && $stable(ovrd_q)));

endmodule

// File: rtl/awd_match.sv
module awd_match
   import awd_pkg::*;
#(
   parameter int unsigned NUM_WIN = 4
) (
   input  awd_hi_t                             addr_hi,
   input  logic                                is_write,
   input  awd_word_t                           ctrl,
   input  logic [NUM_WIN-1:0][AWD_WORD_W-1:0]  base,
   input  logic [NUM_WIN-1:0][AWD_WORD_W-1:0]  mask,
   output logic [NUM_WIN-1:0]                  cand,
   output logic [NUM_WIN-1:0]                  perm
);

   for (genvar g = 0; g < NUM_WIN; g++) begin : g_cmp
      localparam int unsigned FL = awd_fld_lsb(g);
      logic [1:0] fld;
      awd_hi_t    care;
      awd_hi_t    diff;

      assign fld  = ctrl[FL +: 2];
      assign care = ~mask[g][AWD_WORD_W-1 -: AWD_HI_W];
      assign diff = addr_hi ^ base[g][AWD_WORD_W-1 -: AWD_HI_W];

      assign cand[g] = (fld != 2'b00) && ((diff & care) == '0);
      assign perm[g] = is_write ? fld[1] : fld[0];
   end

endmodule

// File: rtl/awd_pick.sv
module awd_pick #(
   parameter int unsigned N  = 4,
   parameter int unsigned IW = 2
) (
   input  logic [N-1:0]  cand,
   output logic          any,
   output logic [IW-1:0] idx,
   output logic [N-1:0]  grant
);

   always_comb begin
      any   = 1'b0;
      idx   = '0;
      grant = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (cand[i]) begin
            any      = 1'b1;
            idx      = IW'(i);
            grant    = '0;
            grant[i] = 1'b1;
         end
      end
   end

   // R5: a single grant, and only to a candidate
   always_comb begin
      a_r5_one_grant: assert ($onehot0(grant));
      a_r5_grant_is_cand: assert ((grant & ~cand) == '0);
   end

endmodule

// File: rtl/addr_window_decoder.sv
module addr_window_decoder
   import awd_pkg::*;
#(
   parameter int unsigned NUM_WIN = 4,
   localparam int unsigned RIDX_W = $clog2(AWD_SLOT_WIN0 + 2 * NUM_WIN),
   localparam int unsigned WIDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr_en,
   input  logic [RIDX_W-1:0] cfg_wr_idx,
   input  logic [31:0]       cfg_wr_data,
   input  logic [RIDX_W-1:0] cfg_rd_idx,
   output logic [31:0]       cfg_rd_data,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [31:0]       req_addr,
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic              rsp_miss,
   output logic [WIDX_W-1:0] rsp_win,
   output logic [7:0]        rsp_attr
);

   if (NUM_WIN < 1 || NUM_WIN > AWD_MAX_WIN) begin : g_bad_win
      $error("addr_window_decoder: NUM_WIN must lie in 1..8");
   end

   awd_word_t                           ctrl_q;
   logic [NUM_WIN-1:0][AWD_WORD_W-1:0]  base_q;
   logic [NUM_WIN-1:0][AWD_WORD_W-1:0]  mask_q;
   logic [NUM_WIN-1:0]                  cand;
   logic [NUM_WIN-1:0]                  perm;
   logic [NUM_WIN-1:0]                  grant;
   logic                                any_cand;
   logic [WIDX_W-1:0]                   pick_idx;

   awd_regs #(.NUM_WIN(NUM_WIN), .RIDX_W(RIDX_W)) i_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_wr_en),
      .wr_idx  (cfg_wr_idx),
      .wr_data (cfg_wr_data),
      .rd_idx  (cfg_rd_idx),
      .rd_data (cfg_rd_data),
      .ctrl_q  (ctrl_q),
      .base_q  (base_q),
      .mask_q  (mask_q)
   );

   awd_match #(.NUM_WIN(NUM_WIN)) i_match (
      .addr_hi  (req_addr[AWD_WORD_W-1 -: AWD_HI_W]),
      .is_write (req_write),
      .ctrl     (ctrl_q),
      .base     (base_q),
      .mask     (mask_q),
      .cand     (cand),
      .perm     (perm)
   );

   awd_pick #(.N(NUM_WIN), .IW(WIDX_W)) i_pick (
      .cand  (cand),
      .any   (any_cand),
      .idx   (pick_idx),
      .grant (grant)
   );

   logic      allow_d;
   logic      hit_d;
   awd_attr_t attr_d;

   always_comb begin
      allow_d = |(grant & perm);
      hit_d   = any_cand && allow_d;
      attr_d  = '0;
      for (int i = 0; i < NUM_WIN; i++) begin
         if (grant[i] && hit_d) attr_d = base_q[i][AWD_ATTR_LSB +: AWD_ATTR_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
      end else begin
         rsp_valid <= req_valid;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_hit  <= 1'b0;
         rsp_miss <= 1'b0;
         rsp_win  <= '0;
         rsp_attr <= '0;
      end else if (req_valid) begin
         rsp_hit  <= hit_d;
         rsp_miss <= !hit_d;
         rsp_win  <= any_cand ? pick_idx : '0;
         rsp_attr <= attr_d;
      end
   end

   // R3: strobe follows the request by one edge
   a_r3_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   a_r3_valid_fall: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);
   a_r3_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> ($stable(rsp_hit) && $stable(rsp_miss) &&
                      $stable(rsp_win) && $stable(rsp_attr)));

   // R10: hit and miss are exclusive and complete
   a_r10_hit_xor_miss: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_hit != rsp_miss));

   // R6 and R7: a miss never carries an attribute
   a_r6_miss_no_attr: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_miss) |-> (rsp_attr == '0));

endmodule

// File: tb/test_addr_window_decoder.sv
`timescale 1ns/1ps
module test_addr_window_decoder;

   localparam int NW = 4;
   localparam int RW = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr_en = 1'b0;
   logic [RW-1:0] cfg_wr_idx = '0;
   logic [31:0] cfg_wr_data = '0;
   logic [RW-1:0] cfg_rd_idx = '0;
   logic [31:0] cfg_rd_data;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [31:0] req_addr = '0;
   logic        rsp_valid, rsp_hit, rsp_miss;
   logic [1:0]  rsp_win;
   logic [7:0]  rsp_attr;

   int n_vec = 0;
   int n_bad = 0;
   bit done = 0;

   logic [31:0] sh_ctrl;
   logic [31:0] sh_ovrd;
   logic [31:0] sh_base [NW];
   logic [31:0] sh_mask [NW];

   always #4 clk = ~clk;

   addr_window_decoder #(.NUM_WIN(NW)) i_addr_window_decoder (
      .clk(clk), .rst_n(rst_n),
      .cfg_wr_en(cfg_wr_en), .cfg_wr_idx(cfg_wr_idx), .cfg_wr_data(cfg_wr_data),
      .cfg_rd_idx(cfg_rd_idx), .cfg_rd_data(cfg_rd_data),
      .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
      .rsp_win(rsp_win), .rsp_attr(rsp_attr)
   );

   task automatic check(input bit ok, input string tag, input logic [31:0] got,
                        input logic [31:0] exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, got, exp);
      end
   endtask

   task automatic wr_reg(input int idx, input logic [31:0] d);
      cfg_wr_en   = 1'b1;
      cfg_wr_idx  = RW'(idx);
      cfg_wr_data = d;
      @(posedge clk);
      @(negedge clk);
      cfg_wr_en = 1'b0;
      if (idx == 0) sh_ctrl = d;
      else if (idx == 1) sh_ovrd = d;
      else if (idx < 2 + 2 * NW) begin
         if (idx % 2 == 0) sh_base[(idx - 2) / 2] = d;
         else sh_mask[(idx - 3) / 2] = d;
      end
   endtask

   function automatic logic [31:0] shadow(input int idx);
      if (idx == 0) return sh_ctrl;
      if (idx == 1) return sh_ovrd;
      if (idx < 2 + 2 * NW) return (idx % 2 == 0) ? sh_base[(idx - 2) / 2] : sh_mask[(idx - 3) / 2];
      return 32'h0;
   endfunction

   task automatic rd_check(input int idx, input string tag);
      cfg_rd_idx = RW'(idx);
      #1;
      check(cfg_rd_data == shadow(idx), $sformatf("%s slot %0d", tag, idx),
            cfg_rd_data, shadow(idx));
   endtask

   // expected {hit, miss, win[1:0], attr[7:0]} and a requirement tag
   function automatic logic [11:0] model(input logic [31:0] a, input bit w,
                                         output string tag);
      int first = -1;
      int nc = 0;
      for (int i = 0; i < NW; i++) begin
         logic [1:0]  f;
         logic [15:0] d;
         f = sh_ctrl[16 + 2 * i +: 2];
         d = (a[31:16] ^ sh_base[i][31:16]) & ~sh_mask[i][31:16];
         if (f != 2'b00 && d == 16'h0) begin
            nc++;
            if (first < 0) first = i;
         end
      end
      if (first < 0) begin
         tag = "R6";
         return {1'b0, 1'b1, 2'd0, 8'h00};
      end
      if (!sh_ctrl[16 + 2 * first + (w ? 1 : 0)]) begin
         tag = "R7";
         return {1'b0, 1'b1, 2'(first), 8'h00};
      end
      tag = (nc > 1) ? "R5" : "R4 R8";
      return {1'b1, 1'b0, 2'(first), sh_base[first][15:8]};
   endfunction

   task automatic request(input logic [31:0] a, input bit w);
      logic [11:0] exp;
      logic [11:0] got;
      string tag;
      exp = model(a, w, tag);
      req_valid = 1'b1;
      req_write = w;
      req_addr  = a;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      req_addr  = ~a;
      req_write = ~w;
      got = {rsp_hit, rsp_miss, rsp_win, rsp_attr};
      check(rsp_valid == 1'b1, "R3 valid one cycle after request", 32'(rsp_valid), 32'h1);
      check(got == exp && (rsp_hit ^ rsp_miss),
            $sformatf("%s R10 addr=%h wr=%0b {hit,miss,win,attr}", tag, a, w),
            32'(got), 32'(exp));
      @(posedge clk);
      @(negedge clk);
      check(rsp_valid == 1'b0 && {rsp_hit, rsp_miss, rsp_win, rsp_attr} == got,
            "R3 valid drops and fields hold",
            {rsp_valid, 19'h0, rsp_hit, rsp_miss, rsp_win, rsp_attr}, {20'h0, got});
   endtask

   task automatic sweep();
      for (int hi = 0; hi < 65536; hi += 97) begin
         logic [31:0] a;
         a = {16'(hi), 16'(hi * 7 + 3)};
         request(a, 1'b0);
         request(a, 1'b1);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL R3 watchdog actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      sh_ctrl = '0;
      sh_ovrd = '0;
      for (int i = 0; i < NW; i++) begin
         sh_base[i] = '0;
         sh_mask[i] = '0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      check(rsp_valid == 1'b0, "R1 rsp_valid after reset", 32'(rsp_valid), 32'h0);
      for (int s = 0; s < 2 + 2 * NW; s++) rd_check(s, "R1 reset value");

      // configuration A: two DRAM windows, one SRAM window, window 3 off
      wr_reg(2, 32'h0000_0E00); wr_reg(3, 32'h0FFF_0000);
      wr_reg(4, 32'h1000_0E00); wr_reg(5, 32'h0FFF_0000);
      wr_reg(6, 32'h4000_1E00); wr_reg(7, 32'h03FF_0000);
      wr_reg(8, 32'h8000_5500); wr_reg(9, 32'h0000_0000);
      wr_reg(0, 32'h003F_0000);
      wr_reg(1, 32'hDEAD_BEEF);
      for (int s = 0; s < 2 + 2 * NW; s++) rd_check(s, "R2 readback");
      wr_reg(1, 32'h0);
      rd_check(1, "R2 override rewrite");

      // R9: out-of-range slots
      for (int s = 2 + 2 * NW; s < 16; s++) wr_reg(s, 32'hFFFF_FFFF);
      for (int s = 0; s < 16; s++) rd_check(s, "R9 out-of-range access");

      sweep();
      request(32'h0FFF_FFFF, 1'b0);
      request(32'h1000_0000, 1'b1);
      request(32'h43FF_FFFC, 1'b0);
      request(32'h4400_0000, 1'b0);
      request(32'h8000_0000, 1'b0);

      // configuration B: overlap and access rights
      wr_reg(2, 32'h2000_1100); wr_reg(3, 32'h00FF_0000);
      wr_reg(4, 32'h2000_2200); wr_reg(5, 32'h0FFF_0000);
      wr_reg(6, 32'h8000_3300); wr_reg(7, 32'h7FFF_0000);
      wr_reg(8, 32'h8000_4400); wr_reg(9, 32'h0FFF_0000);
      wr_reg(0, 32'h009F_0000);
      for (int s = 0; s < 2 + 2 * NW; s++) rd_check(s, "R2 readback B");
      sweep();
      request(32'h2000_0000, 1'b1);
      request(32'h2100_0000, 1'b0);
      request(32'h8000_0010, 1'b1);
      request(32'h8000_0010, 1'b0);

      // configuration C: low control half set, every window disabled
      wr_reg(0, 32'h0000_FFFF);
      rd_check(0, "R2 readback C");
      sweep();

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule